// File: doc/BRIEF.md
# Multi-Channel Debug Mailbox FIFO

This block connects a CPU to a debug probe through two queues. Each queue entry is a 32-bit data word tagged with a 4-bit channel number. The CPU side is a simple register bus. A write to one of sixteen per-channel transmit addresses queues the write data for the probe and tags it with the channel that the address selects. A read of the receive-data address removes the oldest word the probe has delivered. A status register reports how full each queue is, its empty and full flags, and the channel tag of the oldest received word. This lets software route a word before it reads it.

The probe side has two valid/ready streams. Each stream carries a 36-bit word, with the channel in bits 35:32 and the data in bits 31:0. The outbound stream raises valid whenever the transmit queue holds anything, and a word moves on a clock edge where valid and ready are both high. The inbound stream deasserts ready while the receive queue is full, so the probe must hold its word and valid until ready returns. One level interrupt combines a programmable transmit condition and a programmable receive condition.

Registers and offsets: access scratch at 0x00, configuration at 0x08, status at 0x10, receive data at 0x18, and transmit channel n at 0x20 + 8·n. Reads of bus_rdata are combinational in the cycle that bus_en is high, and writes take effect at the clock edge.

Top module: `dbgchan_periph`

## Requirements
- R1: After reset both queues are empty, both interrupt modes are 0, the access register reads 0, the status register reads 0x0000000A, and irq is low.
- R2: A bus write to offset 0x20 + 8·n (n = 0..15) queues {n, wdata}. The queue presents words on tx_pword (channel in bits 35:32) in write order, and tx_pvalid is high whenever it is non-empty.
- R3: A transmit write while the transmit queue holds TX_DEPTH words is discarded. Occupancy stays at TX_DEPTH and that word never appears at the probe port.
- R4: Configuration bits 19:18 (transmit mode) and 17:16 (receive mode) are read/write. Bits 15:8 read TX_DEPTH and bits 7:0 read RX_DEPTH, and neither field can be written. All other bits read 0.
- R5: Status bits 31:24 give transmit occupancy and bits 23:16 give receive occupancy. Bits 7:4 give the head receive channel, or 0 when the receive queue is empty. Bit 3 is receive empty, bit 2 receive full, bit 1 transmit empty and bit 0 transmit full. Bits 15:8 are 0.
- R6: rx_pready is low exactly when the receive queue holds RX_DEPTH words. A word offered while rx_pready is low is not taken.
- R7: A read of offset 0x18 returns the data of the head receive word and removes it. Words come out in arrival order.
- R8: A read of offset 0x18 while the receive queue is empty returns 0 and changes no state.
- R9: With transmit mode 1 irq is raised while the transmit queue is empty. Mode 2 raises it while the queue is not full, and mode 3 while 4·occupancy ≤ TX_DEPTH. Mode 0 raises nothing.
- R10: With receive mode 1 irq is raised while the receive queue is full. Mode 2 raises it while the queue is not empty, and mode 3 while 4·occupancy ≥ 3·RX_DEPTH. Mode 0 raises nothing. The irq output is the OR of the transmit and receive conditions.
- R11: The access register at 0x00 is a plain 32-bit read/write register.
- R12: Reads of unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high and bus_we is low |
| tx_pvalid | output | 1 | Outbound word available |
| tx_pready | input | 1 | Probe takes the outbound word |
| tx_pword | output | 36 | Outbound {channel, data} |
| rx_pvalid | input | 1 | Probe offers an inbound word |
| rx_pready | output | 1 | Receive queue has room |
| rx_pword | input | 36 | Inbound {channel, data} |
| irq | output | 1 | Level interrupt |

## Verification
A wrong occupancy count would show up in the next status read. It would also show up on the handshake pins in the same cycle, as tx_pvalid on an empty queue or rx_pready low while there is room. A pointer that wraps wrongly would deliver a reordered or stale word at the probe port or at the receive-data read. The scoreboards catch such a word on its first transfer. Because irq depends only on occupancy and the mode registers, a wrong threshold decode would be visible one bus access after the queue crosses the relevant occupancy level.

// File: rtl/dbgchan_pkg.sv
package dbgchan_pkg;
  localparam int CH_W     = 4;
  localparam int DATA_W   = 32;
  localparam int WORD_W   = CH_W + DATA_W;
  localparam int NUM_CH   = 16;
  localparam int ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_ACC  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TX0  = 8'h20;
  localparam int                TX_STRIDE = 8;

  typedef enum logic [1:0] {
    TXI_OFF   = 2'd0,
    TXI_EMPTY = 2'd1,
    TXI_ROOM  = 2'd2,
    TXI_LOW   = 2'd3
  } tx_irq_mode_e;

  typedef enum logic [1:0] {
    RXI_OFF   = 2'd0,
    RXI_FULL  = 2'd1,
    RXI_AVAIL = 2'd2,
    RXI_HIGH  = 2'd3
  } rx_irq_mode_e;

  typedef struct packed {
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] data;
  } chan_word_t;
endpackage

// File: rtl/dbgchan_fifo.sv
module dbgchan_fifo
  import dbgchan_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  chan_word_t       push_word,
  input  logic             pop,
  output chan_word_t       head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  chan_word_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy is bounded by the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R3: a push into a full queue without a pop leaves it unchanged
  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
  // R8: popping an empty queue keeps it empty
  a_r8_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/dbgchan_irq.sv
module dbgchan_irq
  import dbgchan_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tx_irq_mode_e     tx_mode,
  input  rx_irq_mode_e     rx_mode,
  input  logic [TXC_W-1:0] tx_cnt,
  input  logic [RXC_W-1:0] rx_cnt,
  output logic             irq
);
  logic tx_hit, rx_hit;
  logic [31:0] tx_x4, rx_x4;

  assign tx_x4 = 32'(tx_cnt) << 2;
  assign rx_x4 = 32'(rx_cnt) << 2;

  always_comb begin
    unique case (tx_mode)
      TXI_EMPTY: tx_hit = (tx_cnt == '0);
      TXI_ROOM:  tx_hit = (tx_cnt != TXC_W'(TX_DEPTH));
      TXI_LOW:   tx_hit = (tx_x4 <= 32'(TX_DEPTH));
      default:   tx_hit = 1'b0;
    endcase
    unique case (rx_mode)
      RXI_FULL:  rx_hit = (rx_cnt == RXC_W'(RX_DEPTH));
      RXI_AVAIL: rx_hit = (rx_cnt != '0);
      RXI_HIGH:  rx_hit = (rx_x4 >= 32'(3 * RX_DEPTH));
      default:   rx_hit = 1'b0;
    endcase
  end

  assign irq = tx_hit || rx_hit;

  // R9/R10: both modes off keeps the line quiet
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == TXI_OFF && rx_mode == RXI_OFF) |-> !irq);
  // R10: full receive queue in full mode raises the line
  a_r10_full_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == RXI_FULL && rx_cnt == RXC_W'(RX_DEPTH)) |-> irq);
endmodule

// File: rtl/dbgchan_regs.sv
module dbgchan_regs
  import dbgchan_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TXC_W-1:0]  tx_cnt,
  input  logic [RXC_W-1:0]  rx_cnt,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  chan_word_t        rx_head,
  output logic              tx_push,
  output chan_word_t        tx_word,
  output logic              rx_pop,
  output tx_irq_mode_e      tx_mode,
  output rx_irq_mode_e      rx_mode
);
  logic [NUM_CH-1:0] tx_hit;
  logic [CH_W-1:0]   tx_ch;
  logic [DATA_W-1:0] acc_q;
  logic              wr, rd;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_txdec
    assign tx_hit[g] = (bus_addr == ADDR_W'(OFS_TX0 + TX_STRIDE * g));
  end

  always_comb begin
    tx_ch = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (tx_hit[i]) tx_ch = CH_W'(i);
    end
  end

  assign tx_push      = wr && (|tx_hit);
  assign tx_word.ch   = tx_ch;
  assign tx_word.data = bus_wdata;
  assign rx_pop       = rd && (bus_addr == OFS_RXD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      tx_mode <= TXI_OFF;
      rx_mode <= RXI_OFF;
    end else if (wr) begin
      if (bus_addr == OFS_ACC) acc_q <= bus_wdata;
      if (bus_addr == OFS_CFG) begin
        tx_mode <= tx_irq_mode_e'(bus_wdata[19:18]);
        rx_mode <= rx_irq_mode_e'(bus_wdata[17:16]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        OFS_ACC:  bus_rdata = acc_q;
        OFS_CFG:  bus_rdata = {12'h000, tx_mode, rx_mode, 8'(TX_DEPTH), 8'(RX_DEPTH)};
        OFS_STAT: bus_rdata = {8'(tx_cnt), 8'(rx_cnt), 8'h00,
                               rx_empty ? 4'h0 : rx_head.ch,
                               rx_empty, rx_full, tx_empty, tx_full};
        OFS_RXD:  bus_rdata = rx_empty ? '0 : rx_head.data;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4: modes only move on a configuration write
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == OFS_CFG) |=> ($stable(tx_mode) && $stable(rx_mode)));
  // R2: at most one transmit channel decoded per access
  a_r2_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_hit));
endmodule

// File: rtl/dbgchan_periph.sv
module dbgchan_periph
  import dbgchan_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_pvalid,
  input  logic        tx_pready,
  output logic [35:0] tx_pword,
  input  logic        rx_pvalid,
  output logic        rx_pready,
  input  logic [35:0] rx_pword,
  output logic        irq
);
  localparam int TXC_W = $clog2(TX_DEPTH + 1);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);

  chan_word_t       tx_in, tx_head, rx_in, rx_head;
  logic [TXC_W-1:0] tx_cnt;
  logic [RXC_W-1:0] rx_cnt;
  logic             tx_push, tx_empty, tx_full, rx_pop, rx_empty, rx_full;
  tx_irq_mode_e     tx_mode;
  rx_irq_mode_e     rx_mode;

  assign rx_in     = chan_word_t'(rx_pword);
  assign tx_pword  = tx_head;
  assign tx_pvalid = !tx_empty;
  assign rx_pready = !rx_full;

  dbgchan_regs #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_regs (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_cnt, .rx_cnt, .tx_empty, .tx_full, .rx_empty, .rx_full, .rx_head,
    .tx_push, .tx_word(tx_in), .rx_pop, .tx_mode, .rx_mode
  );

  dbgchan_fifo #(.DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .push_word(tx_in), .pop(tx_pready),
    .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  dbgchan_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_pvalid), .push_word(rx_in), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  dbgchan_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
    .clk, .rst_n, .tx_mode, .rx_mode, .tx_cnt, .rx_cnt, .irq
  );

  // R6: no room advertised to the probe once the receive queue is full
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == RXC_W'(RX_DEPTH)) |-> !rx_pready);
  // R2: queued transmit data is always offered
  a_r2_valid_when_data: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt != '0) |-> tx_pvalid);
endmodule

// File: tb/dbgchan_periph_test.sv
`timescale 1ns/1ps
module dbgchan_periph_test;
  import dbgchan_pkg::*;
  localparam int TXD = 8;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_pvalid, tx_pready = 1'b0;
  logic [35:0] tx_pword;
  logic        rx_pvalid = 1'b0, rx_pready;
  logic [35:0] rx_pword = '0;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [35:0] txq [$];
  logic [35:0] rxq [$];
  logic [35:0] mon_exp;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dbgchan_periph #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_pvalid, .tx_pready, .tx_pword, .rx_pvalid, .rx_pready, .rx_pword, .irq
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // transmit driver: records the expected probe-side word unless queue is full
  task automatic tx_send(input int ch, input logic [31:0] d);
    if (txq.size() < TXD) txq.push_back({4'(ch), d});
    bus_write(8'(32'h20 + 8 * ch), d);
  endtask

  task automatic rx_send(input int ch, input logic [31:0] d);
    logic acc;
    @(negedge clk);
    rx_pvalid = 1'b1; rx_pword = {4'(ch), d};
    #1 acc = rx_pready;
    @(negedge clk);
    rx_pvalid = 1'b0;
    if (acc) rxq.push_back({4'(ch), d});
  endtask

  task automatic rx_take();
    logic [31:0] st;
    logic [35:0] e;
    e = rxq.pop_front();
    bus_read(OFS_STAT, st);
    check("R5 head channel", 36'(st[7:4]), 36'(e[35:32]));
    bus_read(OFS_RXD, rd);
    check("R7 receive data", 36'(rd), 36'(e[31:0]));
  endtask

  task automatic drain_tx();
    @(negedge clk);
    tx_pready = 1'b1;
    repeat (TXD + 4) @(negedge clk);
    tx_pready = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1 check(req, 36'(irq), 36'(exp));
  endtask

  // scoreboard monitor for the outbound stream
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_pready && tx_pvalid) begin
      n_run++;
      if (txq.size() == 0) begin
        n_fail++;
        $display("FAIL R2: actual %h expected no word", tx_pword);
      end else begin
        mon_exp = txq.pop_front();
        if (tx_pword !== mon_exp) begin
          n_fail++;
          $display("FAIL R2/R3: actual %h expected %h", tx_pword, mon_exp);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(OFS_STAT, rd); check("R1 status", 36'(rd), 36'h0000000A);
    bus_read(OFS_CFG, rd);  check("R1 cfg", 36'(rd), 36'h00000808);
    bus_read(OFS_ACC, rd);  check("R1 access", 36'(rd), 36'h0);
    irq_chk("R1 irq", 1'b0);

    // R11 access register
    bus_write(OFS_ACC, 32'hDEADBEEF);
    bus_read(OFS_ACC, rd); check("R11 access rw", 36'(rd), 36'hDEADBEEF);

    // R4 configuration fields
    bus_write(OFS_CFG, 32'hFFFFFFFF);
    bus_read(OFS_CFG, rd); check("R4 cfg all ones", 36'(rd), 36'h000F0808);
    bus_write(OFS_CFG, 32'h0);
    bus_read(OFS_CFG, rd); check("R4 cfg cleared", 36'(rd), 36'h00000808);

    // R12 unmapped offsets
    bus_write(8'hA0, 32'h12345678);
    bus_write(8'h22, 32'h12345678);
    bus_read(8'h04, rd); check("R12 unmapped read", 36'(rd), 36'h0);
    bus_read(8'hA0, rd); check("R12 unmapped read", 36'(rd), 36'h0);
    bus_read(OFS_STAT, rd); check("R12 no push", 36'(rd), 36'h0000000A);
    bus_read(OFS_ACC, rd); check("R12 access kept", 36'(rd), 36'hDEADBEEF);

    // R2 and R3: fill past depth on several channels, then drain
    for (int i = 0; i < 10; i++) tx_send((i * 5 + 1) % 16, 32'hA000_0000 + i);
    bus_read(OFS_STAT, rd); check("R3 full status", 36'(rd), 36'h08000009);
    check("R2 valid", 36'(tx_pvalid), 36'h1);
    drain_tx();
    check("R3 dropped never seen", 36'(txq.size()), 36'h0);
    bus_read(OFS_STAT, rd); check("R2 drained", 36'(rd), 36'h0000000A);
    tx_send(15, 32'h0F0F0F0F);
    tx_send(0, 32'h00000001);
    drain_tx();
    check("R2 edge channels", 36'(txq.size()), 36'h0);

    // R9 transmit interrupt modes
    bus_write(OFS_CFG, 32'h00040000); irq_chk("R9 empty mode, empty", 1'b1);
    tx_send(3, 32'h1);                irq_chk("R9 empty mode, one", 1'b0);
    bus_write(OFS_CFG, 32'h000C0000); irq_chk("R9 low mode, one", 1'b1);
    tx_send(3, 32'h2);                irq_chk("R9 low mode, two", 1'b1);
    tx_send(3, 32'h3);                irq_chk("R9 low mode, three", 1'b0);
    bus_write(OFS_CFG, 32'h00080000); irq_chk("R9 room mode, three", 1'b1);
    for (int i = 0; i < 5; i++) tx_send(4, 32'h10 + i);
    irq_chk("R9 room mode, full", 1'b0);
    bus_write(OFS_CFG, 32'h0);        irq_chk("R9 off", 1'b0);
    drain_tx();
    check("R9 queue drained", 36'(txq.size()), 36'h0);

    // R8 empty receive read
    bus_read(OFS_RXD, rd); check("R8 empty read", 36'(rd), 36'h0);
    bus_read(OFS_STAT, rd); check("R8 no state change", 36'(rd), 36'h0000000A);

    // R6 fill receive side
    for (int i = 0; i < RXD; i++) rx_send((i * 3 + 2) % 16, 32'hB000_0000 + i);
    check("R6 ready low when full", 36'(rx_pready), 36'h0);
    rx_send(9, 32'hBAD0BAD0);
    check("R6 refused word", 36'(rxq.size()), 36'(RXD));
    bus_read(OFS_STAT, rd);
    check("R5 rx full status", 36'(rd), 36'h00080006 | 36'(32'(rxq[0][35:32]) << 4));

    // R10 receive interrupt modes
    bus_write(OFS_CFG, 32'h00010000); irq_chk("R10 full mode", 1'b1);
    bus_write(OFS_CFG, 32'h00030000); irq_chk("R10 high mode, eight", 1'b1);
    rx_take(); rx_take();             irq_chk("R10 high mode, six", 1'b1);
    rx_take();                        irq_chk("R10 high mode, five", 1'b0);
    bus_write(OFS_CFG, 32'h00020000); irq_chk("R10 avail mode", 1'b1);
    check("R6 ready after pop", 36'(rx_pready), 36'h1);

    // R7 order across wrap
    rx_send(14, 32'hC0DE0001);
    rx_send(0,  32'hC0DE0002);
    while (rxq.size() > 0) rx_take();
    irq_chk("R10 avail mode, empty", 1'b0);
    bus_read(OFS_STAT, rd); check("R5 final status", 36'(rd), 36'h0000000A);
    bus_write(OFS_CFG, 32'h0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule